// File: doc/BRIEF.md
# Command Ring Free-Space Monitor

This block watches a circular command ring shared by a producer and a consumer. It takes the consumer's head pointer and the producer's tail pointer as byte offsets, together with a ring size programmed as a power of two. From these it derives, every cycle, how many bytes the producer may still write. An 8-byte guard gap is always kept free, so a full ring never looks the same as an empty one.

A producer that wants to write asks for a number of bytes. The block then checks the free space once per cycle. Each check is one poll. The request is granted on the first poll that finds enough room. If the head pointer stops moving and the room never appears, a stall watchdog ends the wait with a one-cycle busy-error pulse. The watchdog restarts its count each time the head moves, so a slow consumer that is still making progress never trips it. A quiescent request waits until the consumer has drained the ring completely. A ring-empty flag and the live free-space figure are also brought out.

Top module: `ring_space_monitor`

## Requirements
- R1: `free_bytes` equals head − (tail + 8), with the ring size added when that difference is negative. Both pointers are taken after the masking of R2. The result therefore lies between 0 and size − 8.
- R2: The ring size is 2^`size_log2` bytes. Each pointer is ANDed with (size − 1) and its three low bits are cleared before use. Pointer bits above the ring size and below 8-byte alignment therefore have no effect.
- R3: `ring_empty` is 1 exactly when the masked head equals the masked tail.
- R4: A request is accepted on a clock edge where `req_valid` is 1 and no request is pending. If the free space on the next edge is at least `req_bytes`, `grant` is 1 for exactly one cycle after that edge and the request ends.
- R5: `wait_flag` is 1 from the edge that accepts a request until the edge that grants it or reports busy. It is 0 at all other times.
- R6: With the head unchanged, the request ends after 10000 consecutive polls that lack room. `busy_err` is then 1 for one cycle and `grant` stays 0.
- R7: A poll that sees a head value different from the previous poll restarts the count at zero. Busy then needs 10000 further unsuccessful polls with the head unchanged.
- R8: When `req_quiesce` is 1 at acceptance, `req_bytes` is ignored. The request is granted only when `free_bytes` equals size − 8, which means the ring is empty.
- R9: When a poll finds enough room on the same edge that the count limit would be reached, `grant` is raised and `busy_err` is not.
- R10: While a request is pending, `req_valid`, `req_bytes` and `req_quiesce` are ignored. The pending size is not replaced.
- R11: After reset, `grant`, `busy_err` and `wait_flag` are 0, and any pending request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_log2 | input | 5 | Ring size exponent; size = 2^size_log2 bytes (4 to 16) |
| head_ptr | input | 16 | Consumer head byte offset |
| tail_ptr | input | 16 | Producer tail byte offset |
| req_valid | input | 1 | Request strobe |
| req_bytes | input | 17 | Bytes requested |
| req_quiesce | input | 1 | Request waits for a fully drained ring |
| grant | output | 1 | One-cycle pulse: request satisfied |
| busy_err | output | 1 | One-cycle pulse: stall timeout |
| wait_flag | output | 1 | Request pending and not yet granted |
| ring_empty | output | 1 | Masked head equals masked tail |
| free_bytes | output | 17 | Current writable bytes |

## Verification
The grant path and the stall timeout can both resolve on the same poll. The bench sets this up by holding the head still until the very poll on which the count would expire. Just before that poll it pulls the tail back, so the room appears without the head moving. The bench expects `grant` high and `busy_err` low at that point. A second case moves the head partway through a stall. It judges that the busy pulse arrives exactly 10000 polls after the poll that saw the move, and not earlier.

// File: rtl/rsm_pkg.sv
package rsm_pkg;

    // Bytes always kept free between tail and head
    localparam int GUARD_BYTES = 8;
    // Pointers are treated as 8-byte aligned
    localparam int ALIGN_BITS  = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_POLL = 1'b1
    } rsm_state_e;

    // Captured request while it is pending
    typedef struct packed {
        logic        quiesce;
        logic [31:0] bytes;
    } rsm_req_t;

    function automatic int unsigned align_clear_mask(input int unsigned w);
        return (w > ALIGN_BITS) ? ALIGN_BITS : w;
    endfunction

endpackage

// File: rtl/rsm_space_calc.sv
module rsm_space_calc
    import rsm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LOG_W  = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOG_W-1:0]  size_log2,
    input  logic [ADDR_W-1:0] head_raw,
    input  logic [ADDR_W-1:0] tail_raw,
    output logic [ADDR_W-1:0] head_m,
    output logic [ADDR_W-1:0] tail_m,
    output logic [ADDR_W:0]   size_bytes,
    output logic [ADDR_W:0]   free_bytes,
    output logic              empty
);
    localparam int CW = ADDR_W + 2;
    localparam int LOWCLR = align_clear_mask(ADDR_W);
    localparam logic [CW-1:0]   GUARD_C = CW'(GUARD_BYTES);
    localparam logic [ADDR_W:0] GUARD_S = (ADDR_W + 1)'(GUARD_BYTES);

    logic [ADDR_W:0]   size_minus1;
    logic [ADDR_W-1:0] ptr_mask;
    logic [CW-1:0]     diff;
    logic [CW-1:0]     wrapped;

    always_comb begin
        size_bytes  = {{ADDR_W{1'b0}}, 1'b1} << size_log2;
        size_minus1 = size_bytes - {{ADDR_W{1'b0}}, 1'b1};
        ptr_mask    = size_minus1[ADDR_W-1:0];
        ptr_mask[LOWCLR-1:0] = '0;
    end

    assign head_m = head_raw & ptr_mask;
    assign tail_m = tail_raw & ptr_mask;

    always_comb begin
        diff    = {2'b00, head_m} - ({2'b00, tail_m} + GUARD_C);
        wrapped = diff;
        if (diff[CW-1]) begin
            wrapped = diff + {1'b0, size_bytes};
        end
    end

    assign free_bytes = wrapped[ADDR_W:0];
    assign empty      = (head_m == tail_m);

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (size_log2 >= LOG_W'(4) && size_log2 <= LOG_W'(ADDR_W)) |-> (free_bytes <= size_bytes - GUARD_S)) // R1
        else $error("free space above size minus guard");
    AST_EMPTY_FULLROOM: assert property (@(posedge clk) disable iff (rst)
        (empty && size_log2 >= LOG_W'(4) && size_log2 <= LOG_W'(ADDR_W)) |-> (free_bytes == size_bytes - GUARD_S)) // R3
        else $error("empty ring without full room");

endmodule

// File: rtl/rsm_poll_ctrl.sv
module rsm_poll_ctrl
    import rsm_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int TIMEOUT = 10000,
    parameter int CNT_W   = $clog2(TIMEOUT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W:0]   req_bytes,
    input  logic              req_quiesce,
    input  logic [ADDR_W:0]   size_bytes,
    input  logic [ADDR_W:0]   free_bytes,
    input  logic [ADDR_W-1:0] head_m,
    output logic              grant,
    output logic              busy_err,
    output logic              waiting
);
    localparam logic [CNT_W-1:0] LAST_POLL = CNT_W'(TIMEOUT - 1);
    localparam logic [ADDR_W:0]  GUARD_S   = (ADDR_W + 1)'(GUARD_BYTES);

    rsm_state_e        state;
    rsm_req_t          pend;
    logic [ADDR_W-1:0] last_head;
    logic [CNT_W-1:0]  poll_cnt;
    logic              room_ok;
    logic              head_moved;
    logic              limit_hit;

    always_comb begin
        if (pend.quiesce) begin
            room_ok = (free_bytes == size_bytes - GUARD_S);
        end else begin
            room_ok = ({{(31 - ADDR_W){1'b0}}, free_bytes} >= pend.bytes);
        end
        head_moved = (head_m != last_head);
        limit_hit  = !head_moved && (poll_cnt == LAST_POLL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend      <= '0;
            last_head <= '0;
            poll_cnt  <= '0;
            grant     <= 1'b0;
            busy_err  <= 1'b0;
        end else begin
            grant    <= 1'b0;
            busy_err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        pend.bytes   <= {{(31 - ADDR_W){1'b0}}, req_bytes};
                        pend.quiesce <= req_quiesce;
                        last_head    <= head_m;
                        poll_cnt     <= '0;
                        state        <= ST_POLL;
                    end
                end
                ST_POLL: begin
                    last_head <= head_m;
                    if (room_ok) begin
                        grant <= 1'b1;
                        state <= ST_IDLE;
                    end else if (limit_hit) begin
                        busy_err <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (head_moved) begin
                        poll_cnt <= '0;
                    end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign waiting = (state == ST_POLL);

    AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (rst)
        grant |=> !grant) // R4
        else $error("grant longer than one cycle");
    AST_BUSY_PULSE: assert property (@(posedge clk) disable iff (rst)
        busy_err |=> !busy_err) // R6
        else $error("busy longer than one cycle");
    AST_BUSY_ENDS_WAIT: assert property (@(posedge clk) disable iff (rst)
        busy_err |-> !waiting) // R6
        else $error("still waiting after busy");
    AST_NO_DOUBLE_END: assert property (@(posedge clk) disable iff (rst)
        !(grant && busy_err)) // R9
        else $error("grant and busy together");
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        poll_cnt < CNT_W'(TIMEOUT)) // R7
        else $error("poll count past limit");
    AST_WAIT_START: assert property (@(posedge clk) disable iff (rst)
        $rose(waiting) |-> $past(req_valid)) // R5
        else $error("wait without request");
    AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
        (waiting && $past(waiting)) |-> $stable(pend)) // R10
        else $error("pending request replaced");

endmodule

// File: rtl/ring_space_monitor.sv
module ring_space_monitor
    import rsm_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int TIMEOUT = 10000,
    parameter int LOG_W   = $clog2(ADDR_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LOG_W-1:0]  size_log2,
    input  logic [ADDR_W-1:0] head_ptr,
    input  logic [ADDR_W-1:0] tail_ptr,
    input  logic              req_valid,
    input  logic [ADDR_W:0]   req_bytes,
    input  logic              req_quiesce,
    output logic              grant,
    output logic              busy_err,
    output logic              wait_flag,
    output logic              ring_empty,
    output logic [ADDR_W:0]   free_bytes
);
    logic [ADDR_W-1:0] head_m;
    logic [ADDR_W-1:0] tail_m;
    logic [ADDR_W:0]   size_bytes;

    rsm_space_calc #(.ADDR_W(ADDR_W), .LOG_W(LOG_W)) space_i (
        .clk        (clk),
        .rst        (rst),
        .size_log2  (size_log2),
        .head_raw   (head_ptr),
        .tail_raw   (tail_ptr),
        .head_m     (head_m),
        .tail_m     (tail_m),
        .size_bytes (size_bytes),
        .free_bytes (free_bytes),
        .empty      (ring_empty)
    );

    rsm_poll_ctrl #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) poll_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_bytes   (req_bytes),
        .req_quiesce (req_quiesce),
        .size_bytes  (size_bytes),
        .free_bytes  (free_bytes),
        .head_m      (head_m),
        .grant       (grant),
        .busy_err    (busy_err),
        .waiting     (wait_flag)
    );

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (rst)
        ring_empty |-> (head_m == tail_m)) // R3
        else $error("empty flag without pointer match");
    AST_GRANT_HAD_WAIT: assert property (@(posedge clk) disable iff (rst)
        grant |-> $past(wait_flag)) // R4
        else $error("grant without pending request");

endmodule

// File: tb/ring_space_monitor_tb.sv
module ring_space_monitor_tb_top;
    localparam int ADDR_W  = 16;
    localparam int TIMEOUT = 10000;
    localparam int LOG_W   = $clog2(ADDR_W + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [LOG_W-1:0]  size_log2 = LOG_W'(8);
    logic [ADDR_W-1:0] head_ptr = '0;
    logic [ADDR_W-1:0] tail_ptr = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W:0]   req_bytes = '0;
    logic              req_quiesce = 1'b0;
    logic              grant, busy_err, wait_flag, ring_empty;
    logic [ADDR_W:0]   free_bytes;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    ring_space_monitor #(.ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT)) dut_i (
        .clk(clk), .rst(rst), .size_log2(size_log2), .head_ptr(head_ptr),
        .tail_ptr(tail_ptr), .req_valid(req_valid), .req_bytes(req_bytes),
        .req_quiesce(req_quiesce), .grant(grant), .busy_err(busy_err),
        .wait_flag(wait_flag), .ring_empty(ring_empty), .free_bytes(free_bytes)
    );

    typedef struct packed {
        logic [4:0]  lg;
        logic [15:0] h;
        logic [15:0] t;
        logic [16:0] fr;
        logic        em;
    } vec_t;

    // size exponent, head, tail, expected free, expected empty
    localparam vec_t VECS [8] = '{
        '{5'd8,  16'h0040, 16'h0020, 17'd24,  1'b0},
        '{5'd8,  16'h0020, 16'h0040, 17'd216, 1'b0},
        '{5'd8,  16'h0010, 16'h0010, 17'd248, 1'b1},
        '{5'd8,  16'h0018, 16'h0010, 17'd0,   1'b0},
        '{5'd8,  16'h0113, 16'h0010, 17'd248, 1'b1},
        '{5'd6,  16'h0008, 16'h0030, 17'd16,  1'b0},
        '{5'd6,  16'h00C7, 16'h0000, 17'd56,  1'b1},
        '{5'd10, 16'h0000, 16'h03F8, 17'd0,   1'b0}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic issue(input int bytes, input logic q);
        @(negedge clk);
        req_valid   = 1'b1;
        req_bytes   = (ADDR_W + 1)'(bytes);
        req_quiesce = q;
        @(negedge clk);
        req_valid   = 1'b0;
        req_quiesce = 1'b0;
    endtask

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic early;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 grant after reset", int'(grant), 0);
        chk("R11 busy after reset", int'(busy_err), 0);
        chk("R11 wait after reset", int'(wait_flag), 0);

        // R1 R2 R3: free space arithmetic and empty flag
        foreach (VECS[i]) begin
            size_log2 = LOG_W'(VECS[i].lg);
            head_ptr  = VECS[i].h;
            tail_ptr  = VECS[i].t;
            #2;
            chk($sformatf("R1 R2 free vec %0d", i), int'(free_bytes), int'(VECS[i].fr));
            chk($sformatf("R3 empty vec %0d", i), int'(ring_empty), int'(VECS[i].em));
        end

        // R4 R5: immediate grant
        size_log2 = LOG_W'(8); head_ptr = 16'h0040; tail_ptr = 16'h0020;
        issue(24, 1'b0);
        chk("R5 wait after accept", int'(wait_flag), 1);
        chk("R4 no grant before poll", int'(grant), 0);
        @(negedge clk);
        chk("R4 grant pulse", int'(grant), 1);
        chk("R5 wait cleared on grant", int'(wait_flag), 0);
        @(negedge clk);
        chk("R4 grant single cycle", int'(grant), 0);

        // R10: second request ignored while pending
        issue(32, 1'b0);
        req_valid = 1'b1; req_bytes = 17'd8;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R10 no grant from ignored request", int'(grant), 0);
        chk("R10 still waiting", int'(wait_flag), 1);
        head_ptr = 16'h0048;
        @(negedge clk);
        chk("R10 grant for original size", int'(grant), 1);

        // R8: quiescent ignores bytes, waits for empty ring
        head_ptr = 16'h0040; tail_ptr = 16'h0020;
        issue(0, 1'b1);
        @(negedge clk);
        chk("R8 no grant while not drained", int'(grant), 0);
        tail_ptr = 16'h0040;
        @(negedge clk);
        chk("R8 grant when drained", int'(grant), 1);

        // R6: stall timeout exactly after limit
        head_ptr = 16'h0040; tail_ptr = 16'h0020;
        issue(100, 1'b0);
        early = 1'b0;
        for (int k = 1; k < TIMEOUT; k++) begin
            @(negedge clk);
            if (busy_err || grant) early = 1'b1;
        end
        chk("R6 no early busy", int'(early), 0);
        @(negedge clk);
        chk("R6 busy at limit", int'(busy_err), 1);
        chk("R6 no grant on timeout", int'(grant), 0);
        chk("R6 wait cleared", int'(wait_flag), 0);
        @(negedge clk);
        chk("R6 busy single cycle", int'(busy_err), 0);

        // R7: head move restarts the count
        issue(100, 1'b0);
        repeat (5000) @(negedge clk);
        head_ptr = 16'h0050;
        early = 1'b0;
        for (int j = 1; j <= TIMEOUT; j++) begin
            @(negedge clk);
            if (busy_err || grant) early = 1'b1;
        end
        chk("R7 no busy before restarted limit", int'(early), 0);
        @(negedge clk);
        chk("R7 busy after restarted limit", int'(busy_err), 1);

        // R9: room appears on the limit poll
        head_ptr = 16'h0020; tail_ptr = 16'h0040;
        issue(230, 1'b0);
        early = 1'b0;
        for (int k = 1; k < TIMEOUT; k++) begin
            @(negedge clk);
            if (busy_err || grant) early = 1'b1;
        end
        chk("R9 nothing before limit poll", int'(early), 0);
        tail_ptr = 16'h0030;
        @(negedge clk);
        chk("R9 grant wins", int'(grant), 1);
        chk("R9 busy suppressed", int'(busy_err), 0);

        // R11: reset drops a pending request
        head_ptr = 16'h0040; tail_ptr = 16'h0020;
        issue(100, 1'b0);
        chk("R11 pending before reset", int'(wait_flag), 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R11 wait dropped by reset", int'(wait_flag), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 idle after reset", int'(wait_flag), 0);

        finish_run();
    end
endmodule